// File: doc/BRIEF.md
# Receive Sample Format Fixer with Raw Capture Monitor

This block sits on a receive sample tap that carries one 12-bit I sample and one 12-bit Q sample per valid pulse. The samples arrive in offset-binary form. The downstream demodulator expects signed two's complement, so the block corrects each lane in line. It inverts the lane MSB and sign-extends the result to 16 bits. The corrected pair leaves the block one clock later, together with a valid strobe that is aligned to it.

In parallel, the block assembles a 32-bit capture debug word. The word describes the raw tap samples, not the corrected ones, so a format mismatch stays visible to whoever reads it. The word holds five sticky activity and sign flags, a wrapping count of valid pulses, and the peak raw magnitude seen so far. A clear input wipes all of these statistics. It does not touch the conversion path.

Top module: `rx_tap_fmt_mon`

## Requirements
- R1: When tap_valid_i is high, out_i_o and out_q_o show the raw 12-bit lane value with bit 11 inverted, sign-extended from that bit to 16 bits, on the next clock. Examples: raw 0x000 gives 0xF800, raw 0x800 gives 0x0000, and raw 0xFFF gives 0x07FF.
- R2: out_valid_o equals tap_valid_i delayed by one clock. While no valid sample arrives, out_i_o and out_q_o hold their last values.
- R3: Debug bit 31 becomes 1 one clock after any accepted valid pulse and stays 1 until a clear.
- R4: Debug bit 30 becomes sticky 1 after a valid sample whose raw I or raw Q value is non-zero.
- R5: Debug bit 29 becomes sticky 1 after a valid pulse that arrives while core_active_i is high.
- R6: Debug bit 28 becomes sticky 1 after a valid sample whose raw I bit 11 is set. Debug bit 27 does the same for raw Q bit 11. Raw values are read as signed 12-bit.
- R7: Debug bits 26:14 hold the number of accepted valid pulses, modulo 8192.
- R8: Debug bits 13:0 hold the running maximum, over accepted valid samples, of max(|I|,|Q|) times 4. Raw values are read as signed 12-bit, so raw 0x800 gives 8192 and raw 0x7FF gives 8188. Samples that are not valid are ignored.
- R9: clear_i zeroes the whole debug word at the next clock and takes priority over a valid pulse in the same cycle. That sample is not counted. The conversion output still updates for it.
- R10: While rst_ni is low, every output is zero.
- R11: In a cycle with neither a valid pulse nor a clear, the debug word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_i_i | input | 12 | Raw offset-binary I sample |
| tap_q_i | input | 12 | Raw offset-binary Q sample |
| tap_valid_i | input | 1 | Raw sample valid pulse |
| core_active_i | input | 1 | Downstream demodulator active flag |
| clear_i | input | 1 | Clears all capture statistics |
| out_i_o | output | 16 | Corrected signed I sample |
| out_q_o | output | 16 | Corrected signed Q sample |
| out_valid_o | output | 1 | Valid for the corrected pair |
| dbg_word_o | output | 32 | Raw capture debug word |

## Verification
The clear of the statistics and the acceptance of a valid sample can fall in the same cycle. The bench provokes this by driving clear_i together with a valid, active, non-zero and negative sample. It then expects an all-zero debug word and a converted output for that same sample. It also drives 8192 back-to-back valid pulses, so that a wrap of the pulse count has to be told apart from a clear: the count returns to zero while the sticky valid flag stays set.

// File: rtl/rx_tap_pkg.sv
package rx_tap_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_I    = 0;
  localparam int unsigned LANE_Q    = 1;
  localparam int unsigned FLAG_W    = 5;

  // field order is the debug word layout, MSB first
  typedef struct packed {
    logic valid_seen;
    logic nonzero_seen;
    logic active_seen;
    logic neg_i_seen;
    logic neg_q_seen;
  } mon_flags_t;
endpackage

// File: rtl/rx_lane_conv.sv
module rx_lane_conv #(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RAW_W-1:0] raw_i,
  output logic [OUT_W-1:0] conv_o
);
  localparam int unsigned EXT_W = OUT_W - RAW_W;

  logic [RAW_W-1:0] flip;
  logic [OUT_W-1:0] conv_d;

  always_comb begin
    flip            = raw_i;
    flip[RAW_W-1]   = ~raw_i[RAW_W-1];
    conv_d          = {{EXT_W{flip[RAW_W-1]}}, flip};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      conv_o <= '0;
    else if (valid_i) conv_o <= conv_d;
  end
endmodule

// File: rtl/rx_peak_trk.sv
module rx_peak_trk #(
  parameter int unsigned RAW_W     = 12,
  parameter int unsigned PEAK_W    = 14,
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic                            clear_i,
  input  logic [NUM_LANES-1:0][RAW_W-1:0] samples_i,
  output logic [PEAK_W-1:0]               peak_o
);
  localparam int unsigned SHIFT = PEAK_W - RAW_W;
  localparam logic [RAW_W-1:0] ONE = RAW_W'(1);

  logic [NUM_LANES-1:0][PEAK_W-1:0] scaled;
  logic [PEAK_W-1:0]                sample_max;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_mag
    logic [RAW_W-1:0] mag;
    // raw field read as signed; the most negative code maps to 2^(RAW_W-1)
    assign mag       = samples_i[g][RAW_W-1] ? (~samples_i[g] + ONE) : samples_i[g];
    assign scaled[g] = {mag, {SHIFT{1'b0}}};
  end

  always_comb begin
    sample_max = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (scaled[l] > sample_max) sample_max = scaled[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               peak_o <= '0;
    else if (clear_i)                          peak_o <= '0;
    else if (valid_i && sample_max > peak_o)   peak_o <= sample_max;
  end
endmodule

// File: rtl/rx_sticky_mon.sv
module rx_sticky_mon import rx_tap_pkg::*; #(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             active_i,
  input  logic             clear_i,
  input  logic [RAW_W-1:0] samp_i_i,
  input  logic [RAW_W-1:0] samp_q_i,
  output mon_flags_t       flags_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      flags_o <= '0;
      count_o <= '0;
    end else if (valid_i) begin
      flags_o.valid_seen   <= 1'b1;
      flags_o.nonzero_seen <= flags_o.nonzero_seen | (|samp_i_i) | (|samp_q_i);
      flags_o.active_seen  <= flags_o.active_seen | active_i;
      flags_o.neg_i_seen   <= flags_o.neg_i_seen | samp_i_i[RAW_W-1];
      flags_o.neg_q_seen   <= flags_o.neg_q_seen | samp_q_i[RAW_W-1];
      count_o              <= count_o + CNT_ONE; // wraps by design
    end
  end
endmodule

// File: rtl/rx_tap_fmt_mon.sv
module rx_tap_fmt_mon import rx_tap_pkg::*; #(
  parameter int unsigned RAW_W  = 12,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned PEAK_W = 14
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [RAW_W-1:0]                tap_i_i,
  input  logic [RAW_W-1:0]                tap_q_i,
  input  logic                            tap_valid_i,
  input  logic                            core_active_i,
  input  logic                            clear_i,
  output logic [OUT_W-1:0]                out_i_o,
  output logic [OUT_W-1:0]                out_q_o,
  output logic                            out_valid_o,
  output logic [FLAG_W+CNT_W+PEAK_W-1:0]  dbg_word_o
);
  logic [NUM_LANES-1:0][RAW_W-1:0] raw_lanes;
  logic [NUM_LANES-1:0][OUT_W-1:0] conv_lanes;
  mon_flags_t                      flags;
  logic [CNT_W-1:0]                vcount;
  logic [PEAK_W-1:0]               peak;

  assign raw_lanes[LANE_I] = tap_i_i;
  assign raw_lanes[LANE_Q] = tap_q_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rx_lane_conv #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_conv (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (tap_valid_i),
      .raw_i   (raw_lanes[g]),
      .conv_o  (conv_lanes[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= tap_valid_i;
  end

  assign out_i_o = conv_lanes[LANE_I];
  assign out_q_o = conv_lanes[LANE_Q];

  // statistics watch the raw lanes, never the corrected ones
  rx_sticky_mon #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (tap_valid_i),
    .active_i (core_active_i),
    .clear_i  (clear_i),
    .samp_i_i (tap_i_i),
    .samp_q_i (tap_q_i),
    .flags_o  (flags),
    .count_o  (vcount)
  );

  rx_peak_trk #(.RAW_W(RAW_W), .PEAK_W(PEAK_W), .NUM_LANES(NUM_LANES)) u_peak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (tap_valid_i),
    .clear_i   (clear_i),
    .samples_i (raw_lanes),
    .peak_o    (peak)
  );

  assign dbg_word_o = {flags, vcount, peak};
endmodule

// File: rtl/rx_tap_fmt_mon_chk.sv
module rx_tap_fmt_mon_chk import rx_tap_pkg::*; #(
  parameter int unsigned RAW_W  = 12,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned PEAK_W = 14
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [RAW_W-1:0]               tap_i_i,
  input logic [RAW_W-1:0]               tap_q_i,
  input logic                           tap_valid_i,
  input logic                           core_active_i,
  input logic                           clear_i,
  input logic [OUT_W-1:0]               out_i_o,
  input logic [OUT_W-1:0]               out_q_o,
  input logic                           out_valid_o,
  input logic [FLAG_W+CNT_W+PEAK_W-1:0] dbg_word_o
);
  localparam int unsigned DBG_W   = FLAG_W + CNT_W + PEAK_W;
  localparam int unsigned CNT_LSB = PEAK_W;
  localparam int unsigned CNT_MSB = PEAK_W + CNT_W - 1;
  localparam int unsigned EXT_N   = OUT_W - RAW_W + 1;

  logic [CNT_W-1:0]  cnt_f;
  logic [PEAK_W-1:0] peak_f;
  assign cnt_f  = dbg_word_o[CNT_MSB:CNT_LSB];
  assign peak_f = dbg_word_o[PEAK_W-1:0];

  // R2
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_i |=> out_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tap_valid_i |=> !out_valid_o);
  // R1
  conv_i_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_i |=> (out_i_o[RAW_W-1] != $past(tap_i_i[RAW_W-1])) &&
      ($countones(out_i_o[OUT_W-1:RAW_W-1]) == 0 || $countones(out_i_o[OUT_W-1:RAW_W-1]) == EXT_N));
  // R1
  conv_q_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_i |=> (out_q_o[RAW_W-1] != $past(tap_q_i[RAW_W-1])) &&
      ($countones(out_q_o[OUT_W-1:RAW_W-1]) == 0 || $countones(out_q_o[OUT_W-1:RAW_W-1]) == EXT_N));
  // R3
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_word_o[DBG_W-1] && !clear_i) |=> dbg_word_o[DBG_W-1]);
  // R5
  active_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid_i && core_active_i && !clear_i) |=> dbg_word_o[DBG_W-3]);
  // R6
  neg_i_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid_i && tap_i_i[RAW_W-1] && !clear_i) |=> dbg_word_o[DBG_W-4]);
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid_i && !clear_i) |=> cnt_f == $past(cnt_f) + CNT_W'(1));
  // R8
  peak_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> peak_f >= $past(peak_f));
  // R9
  clear_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> dbg_word_o == '0);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tap_valid_i && !clear_i) |=> $stable(dbg_word_o));
endmodule

bind rx_tap_fmt_mon rx_tap_fmt_mon_chk #(
  .RAW_W(RAW_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .PEAK_W(PEAK_W)
) u_chk (.*);

// File: tb/rx_tap_fmt_mon_tb.sv
module rx_tap_fmt_mon_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [11:0] tap_i, tap_q;
  logic        tap_valid, core_active, clear;
  logic [15:0] out_i, out_q;
  logic        out_valid;
  logic [31:0] dbg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state, built from the requirements
  bit          m_vs, m_nz, m_act, m_ni, m_nq, m_ov;
  int          m_cnt, m_peak;
  logic [15:0] m_oi, m_oq;

  always #2 clk = ~clk;

  rx_tap_fmt_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tap_i_i(tap_i), .tap_q_i(tap_q),
    .tap_valid_i(tap_valid), .core_active_i(core_active), .clear_i(clear),
    .out_i_o(out_i), .out_q_o(out_q), .out_valid_o(out_valid), .dbg_word_o(dbg)
  );

  function automatic logic [15:0] conv16(logic [11:0] x);
    return {{5{~x[11]}}, x[10:0]};
  endfunction

  function automatic int mag4(logic [11:0] x);
    int v;
    v = x[11] ? int'(x) - 4096 : int'(x);
    if (v < 0) v = -v;
    return v * 4;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 out_valid", out_valid, m_ov);
    chk("R1 out_i", out_i, m_oi);
    chk("R1 out_q", out_q, m_oq);
    chk("R3 valid_seen bit31", dbg[31], m_vs);
    chk("R4 nonzero bit30", dbg[30], m_nz);
    chk("R5 active bit29", dbg[29], m_act);
    chk("R6 neg_i bit28", dbg[28], m_ni);
    chk("R6 neg_q bit27", dbg[27], m_nq);
    chk("R7 count 26:14", dbg[26:14], m_cnt % 8192);
    chk("R8 peak 13:0", dbg[13:0], m_peak);
  endtask

  // called at a falling edge; spans exactly one rising edge
  task automatic apply(logic [11:0] i, logic [11:0] q, bit v, bit act, bit clr, bit do_chk);
    tap_i = i; tap_q = q; tap_valid = v; core_active = act; clear = clr;
    if (clr) begin
      m_vs = 0; m_nz = 0; m_act = 0; m_ni = 0; m_nq = 0; m_cnt = 0; m_peak = 0;
    end else if (v) begin
      m_vs = 1;
      if (i != 0 || q != 0) m_nz = 1;
      if (act) m_act = 1;
      if (i[11]) m_ni = 1;
      if (q[11]) m_nq = 1;
      m_cnt = (m_cnt + 1) % 8192;
      if (mag4(i) > m_peak) m_peak = mag4(i);
      if (mag4(q) > m_peak) m_peak = mag4(q);
    end
    if (v) begin m_oi = conv16(i); m_oq = conv16(q); end
    m_ov = v;
    @(negedge clk);
    if (do_chk) check_all();
  endtask

  task automatic t_reset();
    chk("R10 reset out_valid", out_valid, 0);
    chk("R10 reset out_i", out_i, 0);
    chk("R10 reset out_q", out_q, 0);
    chk("R10 reset dbg", dbg, 0);
  endtask

  task automatic t_convert();
    apply(12'h000, 12'h800, 1, 0, 0, 1);
    chk("R1 raw 000 -> F800", out_i, 16'hF800);
    chk("R1 raw 800 -> 0000", out_q, 16'h0000);
    apply(12'hFFF, 12'h7FF, 1, 0, 0, 1);
    chk("R1 raw FFF -> 07FF", out_i, 16'h07FF);
    chk("R1 raw 7FF -> FFFF", out_q, 16'hFFFF);
    apply(12'h123, 12'hABC, 0, 0, 0, 1); // R2 hold while not valid
    apply(12'h9A5, 12'h35A, 1, 0, 0, 1);
    chk("R5 inactive core leaves bit29", dbg[29], 0);
  endtask

  task automatic t_sticky();
    apply(12'h000, 12'h000, 0, 0, 1, 1);
    apply(12'h000, 12'h000, 1, 0, 0, 1);
    chk("R3 valid seen with zero data", dbg[31], 1);
    chk("R4 zero data keeps bit30 low", dbg[30], 0);
    apply(12'h001, 12'h000, 1, 1, 0, 1);
    chk("R4 nonzero raw sets bit30", dbg[30], 1);
    chk("R5 active core sets bit29", dbg[29], 1);
    apply(12'h800, 12'h001, 1, 0, 0, 1);
    chk("R6 raw I negative", dbg[28], 1);
    chk("R6 raw Q still positive", dbg[27], 0);
    apply(12'h000, 12'hC00, 1, 0, 0, 1);
    chk("R6 raw Q negative", dbg[27], 1);
    chk("R3 flags stay sticky", dbg[31:27], 5'b11111);
  endtask

  task automatic t_peak();
    logic [31:0] prev;
    apply(12'h000, 12'h000, 0, 0, 1, 1);
    prev = dbg;
    apply(12'h800, 12'hFFF, 0, 1, 0, 1);
    chk("R11 invalid sample leaves word", dbg, prev);
    chk("R8 invalid sample ignored", dbg[13:0], 0);
    apply(12'h7FF, 12'h010, 1, 0, 0, 1);
    chk("R8 peak 7FF -> 8188", dbg[13:0], 8188);
    apply(12'h001, 12'h800, 1, 0, 0, 1);
    chk("R8 peak 800 -> 8192", dbg[13:0], 8192);
    apply(12'h100, 12'hF00, 1, 0, 0, 1);
    chk("R8 smaller sample keeps peak", dbg[13:0], 8192);
    apply(12'h000, 12'h000, 0, 0, 1, 1);
    apply(12'hFFF, 12'h002, 1, 0, 0, 1);
    chk("R8 raw FFF reads as -1", dbg[13:0], 8);
  endtask

  task automatic t_clear_collide();
    apply(12'h400, 12'h000, 1, 1, 0, 1);
    apply(12'h955, 12'h8AA, 1, 1, 1, 1);
    chk("R9 clear beats valid", dbg, 0);
    chk("R9 converter unaffected by clear", out_i, 16'h0155);
    chk("R9 out_valid unaffected by clear", out_valid, 1);
  endtask

  task automatic t_wrap();
    apply(12'h000, 12'h000, 0, 0, 1, 1);
    for (int n = 0; n < 8191; n++) apply(12'h000, 12'h000, 1, 0, 0, 0);
    chk("R7 count 8191", dbg[26:14], 13'h1FFF);
    apply(12'h000, 12'h000, 1, 0, 0, 1);
    chk("R7 count wraps to 0", dbg[26:14], 0);
    chk("R3 valid flag survives wrap", dbg[31], 1);
    apply(12'h000, 12'h000, 1, 0, 0, 1);
    chk("R7 count after wrap", dbg[26:14], 1);
  endtask

  initial begin
    rst_ni = 1'b0;
    tap_i = '0; tap_q = '0; tap_valid = 0; core_active = 0; clear = 0;
    m_vs = 0; m_nz = 0; m_act = 0; m_ni = 0; m_nq = 0; m_ov = 0;
    m_cnt = 0; m_peak = 0; m_oi = '0; m_oq = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_convert();
    t_sticky();
    t_peak();
    t_clear_collide();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule